// File: doc/BRIEF.md
# Prioritized Interrupt Controller Bank

This block gathers 32 interrupt request lines into one bank and presents up to two requests to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). Each line has its own configuration word that chooses edge or level sensing, picks which of the two requests it feeds, and gives it a 5-bit priority. Lines are latched in a pending register and can be blocked by a per-line mask bit and by a bank-wide block bit.

For each request output, an arbiter chooses among the unmasked pending lines routed to it. The chosen line number is frozen in a readable "sorted" register and the output is held until software writes the matching acknowledge bit in the control register. That write starts a fresh arbitration. A parameter marks the bank as first-level. Only a first-level bank can steer lines to the fast request. A second bank is cascaded by wiring its `irq_o` into one input line of the first bank.

The register bus uses word addresses: an address, a write-data word and a write strobe that takes effect at the clock edge. Read data is combinational from the address.

Top module: `prio_irq_bank`

## Requirements
- R1: After synchronous reset every line is masked (mask reads 0xFFFFFFFF), the bank block bit reads 1, pending reads 0, all configuration words read 0, and both outputs are low.
- R2: Mask register (address 0x00): bit n set to 1 stops line n from taking part in arbitration. An edge on a masked line is still latched into pending. A line that is pending when its mask bit is cleared is arbitrated normally.
- R3: A line whose trigger bit (configuration bit 1) is 0 is edge sensitive. A rising edge, seen against the input value of the previous cycle, sets its pending bit at that clock edge, and the bit stays set after the input falls.
- R4: A line whose trigger bit is 1 is level sensitive. Its pending bit (address 0x01) follows the input with one cycle of delay and is never latched.
- R5: The arbiter takes the unmasked pending line with the smallest priority value. On a tie the lowest line index wins. The sorted registers (IRQ at 0x02, FIQ at 0x03) read bit 7 = winner held and bits 4:0 = winner index.
- R6: Once captured, a winner's index and its output stay unchanged until the matching acknowledge bit is written. This holds even if the line stops pending or a better line arrives.
- R7: Control register (address 0x04, write only, reads 0): writing bit 0 releases the IRQ winner and writing bit 1 releases the FIQ winner. The released output is low in the cycle after the write and re-arbitrates at the next edge. An edge-sensitive winner has its pending bit cleared by the release.
- R8: Configuration bit 0 set to 1 routes the line to `fiq_o` and set to 0 routes it to `irq_o`. When FIRST_LEVEL is 0, that bit is stored and read as 0, so every line goes to `irq_o`.
- R9: A write to the pending register ANDs the write data into the edge-latched bits. Writing 0 clears every latched edge source.
- R10: Block register (address 0x05, bit 0, reset value 1): while it is 1, both outputs are low, although winners are still captured and held.
- R11: Line n's configuration word is at address 0x20 + n. Bits 6:2 hold the priority, bit 1 holds the trigger type and bit 0 holds the routing. It reads back as written, with the R8 rule applied.
- R12: `irq_o` / `fiq_o` is high exactly when that channel holds a winner and the block bit is 0. An edge latched at clock edge k gives a winner at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 32 | Interrupt request lines |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The collisions that matter are an acknowledge write that lands in the same cycle as a new rising edge on the line being released, and a pending-register write that coincides with an incoming edge or with an arbitration capture. Directed steps release a winner while a tied line waits. The random phase drives sparse input toggles together with random writes to the control, pending, mask and configuration registers, so these events overlap many times. Every cycle, both outputs and the read data are compared with a cycle-level model, kept in the bench, that applies the latch, clear and capture rules in the order the requirements give.

// File: rtl/pib_pkg.sv
package pib_pkg;

    localparam int unsigned LINES  = 32;
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned PRIO_W = 5;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned NCHAN  = 2;
    localparam int unsigned CFG_W  = PRIO_W + 2;

    localparam int unsigned CH_IRQ = 0;
    localparam int unsigned CH_FIQ = 1;

    localparam logic [ADDR_W-1:0] ADR_MASK = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_PEND = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_SIRQ = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_SFIQ = 8'h03;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 8'h04;
    localparam logic [ADDR_W-1:0] ADR_GBLK = 8'h05;
    localparam logic [ADDR_W-IDX_W-1:0] CFG_PAGE = 3'b001;

    // Per-line configuration word: bit0 routing, bit1 trigger, bits 6:2 priority
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        logic              to_fiq;
    } line_cfg_t;

    typedef struct packed {
        logic             found;
        logic [IDX_W-1:0] idx;
    } win_t;

    function automatic logic is_cfg_addr(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:IDX_W] == CFG_PAGE;
    endfunction

    function automatic line_cfg_t cfg_from_word(input logic [DATA_W-1:0] w,
                                                input logic first_level);
        line_cfg_t c;
        c        = line_cfg_t'(w[CFG_W-1:0]);
        c.to_fiq = c.to_fiq & first_level;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] sorted_word(input logic v,
                                                      input logic [IDX_W-1:0] idx);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[7]     = v;
        w[IDX_W-1:0] = idx;
        return w;
    endfunction

endpackage

// File: rtl/pib_regs.sv
module pib_regs
    import pib_pkg::*;
#(
    parameter bit FIRST_LEVEL = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    input  logic                          bus_we,
    output logic [LINES-1:0]              mask_q,
    output logic                          glb_block_q,
    output line_cfg_t [LINES-1:0]         cfg_q,
    output logic [NCHAN-1:0]              ack_str,
    output logic                          pend_wr
);

    logic wr_mask, wr_gblk, wr_cfg;

    assign wr_mask = bus_we && (bus_addr == ADR_MASK);
    assign wr_gblk = bus_we && (bus_addr == ADR_GBLK);
    assign wr_cfg  = bus_we && is_cfg_addr(bus_addr);
    assign pend_wr = bus_we && (bus_addr == ADR_PEND);
    assign ack_str = (bus_we && (bus_addr == ADR_CTRL)) ? bus_wdata[NCHAN-1:0]
                                                        : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q      <= '1;
            glb_block_q <= 1'b1;
        end else begin
            if (wr_mask) mask_q      <= bus_wdata[LINES-1:0];
            if (wr_gblk) glb_block_q <= bus_wdata[0];
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        line_cfg_t r;
        logic      sel;
        assign sel = wr_cfg && (bus_addr[IDX_W-1:0] == IDX_W'(g));
        always_ff @(posedge clk) begin
            if (rst)      r <= '0;
            else if (sel) r <= cfg_from_word(bus_wdata, FIRST_LEVEL);
        end
        assign cfg_q[g] = r;
    end

endmodule

// File: rtl/pib_pending.sv
module pib_pending
    import pib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] src_i,
    input  logic [LINES-1:0] level_sel,
    input  logic [LINES-1:0] clr,
    input  logic             pend_wr,
    input  logic [LINES-1:0] pend_wmask,
    output logic [LINES-1:0] pend_q
);

    logic [LINES-1:0] src_q, rise, edge_next, pend_n;

    assign rise      = src_i & ~src_q;
    assign edge_next = (pend_q | rise) & ~clr & (pend_wr ? pend_wmask : '1);
    assign pend_n    = (level_sel & src_i) | (~level_sel & edge_next);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            pend_q <= '0;
        end else begin
            src_q  <= src_i;
            pend_q <= pend_n;
        end
    end

endmodule

// File: rtl/pib_arbiter.sv
module pib_arbiter
    import pib_pkg::*;
(
    input  logic [LINES-1:0]             cand,
    input  logic [LINES-1:0][PRIO_W-1:0] prio,
    output win_t                         win
);

    always_comb begin
        logic [PRIO_W-1:0] best;
        best = '0;
        win  = '0;
        for (int i = 0; i < LINES; i++) begin
            if (cand[i] && (!win.found || (prio[i] < best))) begin
                win.found = 1'b1;
                win.idx   = IDX_W'(i);
                best      = prio[i];
            end
        end
    end

endmodule

// File: rtl/pib_hold.sv
module pib_hold
    import pib_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ack,
    input  win_t             win,
    output logic             vld_q,
    output logic [IDX_W-1:0] idx_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            idx_q <= '0;
        end else if (ack) begin
            vld_q <= 1'b0;
        end else if (!vld_q && win.found) begin
            vld_q <= 1'b1;
            idx_q <= win.idx;
        end
    end

endmodule

// File: rtl/prio_irq_bank.sv
module prio_irq_bank
    import pib_pkg::*;
#(
    parameter bit FIRST_LEVEL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINES-1:0]  src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    logic [LINES-1:0]             mask_q, pend_q, clr, route, level_sel;
    logic                         glb_block;
    line_cfg_t [LINES-1:0]        cfg_q;
    logic [NCHAN-1:0]             ack_str, hold_vld;
    logic [NCHAN-1:0][IDX_W-1:0]  hold_idx;
    logic                         pend_wr;
    logic [LINES-1:0][PRIO_W-1:0] prio;
    logic [NCHAN-1:0][LINES-1:0]  cand;
    win_t [NCHAN-1:0]             win;

    pib_regs #(.FIRST_LEVEL(FIRST_LEVEL)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_we      (bus_we),
        .mask_q      (mask_q),
        .glb_block_q (glb_block),
        .cfg_q       (cfg_q),
        .ack_str     (ack_str),
        .pend_wr     (pend_wr)
    );

    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            route[i]     = cfg_q[i].to_fiq;
            level_sel[i] = cfg_q[i].level;
            prio[i]      = cfg_q[i].prio;
        end
    end

    // Release of an edge-sensitive winner clears its latch
    always_comb begin
        clr = '0;
        for (int c = 0; c < NCHAN; c++) begin
            if (ack_str[c] && hold_vld[c] && !cfg_q[hold_idx[c]].level)
                clr[hold_idx[c]] = 1'b1;
        end
    end

    pib_pending pend_i (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src_i),
        .level_sel  (level_sel),
        .clr        (clr),
        .pend_wr    (pend_wr),
        .pend_wmask (bus_wdata[LINES-1:0]),
        .pend_q     (pend_q)
    );

    for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
        if (ch == CH_FIQ) begin : g_sel_fiq
            assign cand[ch] = pend_q & ~mask_q & route;
        end else begin : g_sel_irq
            assign cand[ch] = pend_q & ~mask_q & ~route;
        end

        pib_arbiter arb_i (
            .cand (cand[ch]),
            .prio (prio),
            .win  (win[ch])
        );

        pib_hold hold_i (
            .clk   (clk),
            .rst   (rst),
            .ack   (ack_str[ch]),
            .win   (win[ch]),
            .vld_q (hold_vld[ch]),
            .idx_q (hold_idx[ch])
        );
    end

    assign irq_o = hold_vld[CH_IRQ] & ~glb_block;
    assign fiq_o = hold_vld[CH_FIQ] & ~glb_block;

    always_comb begin
        bus_rdata = '0;
        if (is_cfg_addr(bus_addr)) begin
            bus_rdata[CFG_W-1:0] = cfg_q[bus_addr[IDX_W-1:0]];
        end else begin
            case (bus_addr)
                ADR_MASK: bus_rdata[LINES-1:0] = mask_q;
                ADR_PEND: bus_rdata[LINES-1:0] = pend_q;
                ADR_SIRQ: bus_rdata = sorted_word(hold_vld[CH_IRQ], hold_idx[CH_IRQ]);
                ADR_SFIQ: bus_rdata = sorted_word(hold_vld[CH_FIQ], hold_idx[CH_FIQ]);
                ADR_GBLK: bus_rdata[0] = glb_block;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/prio_irq_bank_chk.sv
module prio_irq_bank_chk
    import pib_pkg::*;
#(
    parameter bit FIRST_LEVEL = 1'b1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         irq_o,
    input logic                         fiq_o,
    input logic                         glb_block,
    input logic [NCHAN-1:0]             ack_str,
    input logic [NCHAN-1:0]             hold_vld,
    input logic [NCHAN-1:0][IDX_W-1:0]  hold_idx
);

    p_gate_r10: assert property (@(posedge clk) disable iff (rst)
        glb_block |-> (!irq_o && !fiq_o));

    p_gap_irq_r7: assert property (@(posedge clk) disable iff (rst)
        ack_str[CH_IRQ] |=> !irq_o);

    p_gap_fiq_r7: assert property (@(posedge clk) disable iff (rst)
        ack_str[CH_FIQ] |=> !fiq_o);

    p_freeze_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_vld[CH_IRQ] && !ack_str[CH_IRQ]) |=>
            (hold_vld[CH_IRQ] && $stable(hold_idx[CH_IRQ])));

    p_freeze_fiq_r6: assert property (@(posedge clk) disable iff (rst)
        (hold_vld[CH_FIQ] && !ack_str[CH_FIQ]) |=>
            (hold_vld[CH_FIQ] && $stable(hold_idx[CH_FIQ])));

    if (!FIRST_LEVEL) begin : g_no_fast
        p_no_fiq_r8: assert property (@(posedge clk) disable iff (rst)
            !hold_vld[CH_FIQ] && !fiq_o);
    end

endmodule

bind prio_irq_bank prio_irq_bank_chk #(.FIRST_LEVEL(FIRST_LEVEL)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o),
    .glb_block (glb_block),
    .ack_str   (ack_str),
    .hold_vld  (hold_vld),
    .hold_idx  (hold_idx)
);

// File: tb/prio_irq_bank_tb_top.sv
`timescale 1ns/1ps
module prio_irq_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] src = '0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata, rdata2;
    logic        irq_o, fiq_o, irq2, fiq2;

    int n_chk = 0;
    int n_err = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_irq_bank #(.FIRST_LEVEL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o));

    prio_irq_bank #(.FIRST_LEVEL(1'b0)) dut2_i (
        .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wdata(wdata),
        .bus_we(we), .bus_rdata(rdata2), .irq_o(irq2), .fiq_o(fiq2));

    // ---------------- reference model of the first-level bank ----------------
    logic [31:0] m_mask, m_pend, m_srcq;
    logic        m_gblk;
    logic [6:0]  m_cfg [32];
    logic        m_v   [2];
    logic [4:0]  m_idx [2];
    logic [31:0] t_np, t_clr;
    logic [1:0]  t_ack;
    int          t_w [2];

    function automatic int model_win(input int ch);
        int best = -1;
        int bp = 0;
        for (int i = 0; i < 32; i++) begin
            if (m_pend[i] && !m_mask[i] && (int'(m_cfg[i][0]) == ch) &&
                (best < 0 || int'(m_cfg[i][6:2]) < bp)) begin
                best = i;
                bp   = int'(m_cfg[i][6:2]);
            end
        end
        return best;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[7:5] == 3'b001) return {25'b0, m_cfg[a[4:0]]};
        case (a)
            8'h00:   return m_mask;
            8'h01:   return m_pend;
            8'h02:   return {24'b0, m_v[0], 2'b00, m_idx[0]};
            8'h03:   return {24'b0, m_v[1], 2'b00, m_idx[1]};
            8'h05:   return {31'b0, m_gblk};
            default: return 32'b0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mask <= '1; m_pend <= '0; m_srcq <= '0; m_gblk <= 1'b1;
            for (int i = 0; i < 32; i++) m_cfg[i] <= '0;
            for (int c = 0; c < 2; c++) begin m_v[c] <= 1'b0; m_idx[c] <= '0; end
        end else begin
            t_ack = (we && addr == 8'h04) ? wdata[1:0] : 2'b00;
            for (int c = 0; c < 2; c++) t_w[c] = model_win(c);
            t_clr = '0;
            for (int c = 0; c < 2; c++)
                if (t_ack[c] && m_v[c] && !m_cfg[m_idx[c]][1]) t_clr[m_idx[c]] = 1'b1;
            for (int i = 0; i < 32; i++) begin
                if (m_cfg[i][1]) t_np[i] = src[i];
                else begin
                    t_np[i] = (m_pend[i] | (src[i] & ~m_srcq[i])) & ~t_clr[i];
                    if (we && addr == 8'h01) t_np[i] = t_np[i] & wdata[i];
                end
            end
            for (int c = 0; c < 2; c++) begin
                if (t_ack[c]) m_v[c] <= 1'b0;
                else if (!m_v[c] && t_w[c] >= 0) begin
                    m_v[c]   <= 1'b1;
                    m_idx[c] <= t_w[c][4:0];
                end
            end
            m_pend <= t_np;
            m_srcq <= src;
            if (we && addr == 8'h00) m_mask <= wdata;
            if (we && addr == 8'h05) m_gblk <= wdata[0];
            if (we && addr[7:5] == 3'b001) m_cfg[addr[4:0]] <= wdata[6:0];
        end
    end

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (chk_on) begin
            check("R12 irq_o vs model", {31'b0, irq_o}, {31'b0, m_v[0] & ~m_gblk});
            check("R8 fiq_o vs model",  {31'b0, fiq_o}, {31'b0, m_v[1] & ~m_gblk});
            check("R5 bus_rdata vs model", rdata, exp_rd(addr));
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        tick();
        we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        tick();
        check(tag, rdata, exp);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic pulse(input logic [31:0] v);
        src = v;
        tick();
        src = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        chk_on = 1'b1;

        // R1: reset state
        check("R1 irq_o low", {31'b0, irq_o}, 32'h0);
        check("R1 fiq_o low", {31'b0, fiq_o}, 32'h0);
        rd("R1 mask all set", 8'h00, 32'hFFFF_FFFF);
        rd("R1 block bit set", 8'h05, 32'h1);
        rd("R1 pending clear", 8'h01, 32'h0);
        rd("R1 cfg line 0 zero", 8'h20, 32'h0);

        // R11: configuration words
        wr(8'h05, 32'h0);
        wr(8'h00, 32'h0);
        wr(8'h25, 32'h0C);
        wr(8'h29, 32'h04);
        wr(8'h2C, 32'h04);
        rd("R11 cfg line 9 readback", 8'h29, 32'h04);
        rd("R11 cfg line 5 readback", 8'h25, 32'h0C);

        // R3 / R5: edge latch and priority pick
        pulse(32'h0000_1220);
        idle(4);
        check("R12 irq_o raised", {31'b0, irq_o}, 32'h1);
        rd("R5 lowest priority value wins", 8'h02, 32'h89);
        rd("R3 edges stay latched", 8'h01, 32'h0000_1220);

        // R7: release, gap cycle, tie goes to lowest index
        wr(8'h04, 32'h1);
        check("R7 output low after release", {31'b0, irq_o}, 32'h0);
        addr = 8'h02;
        tick();
        check("R7 re-arbitrated output", {31'b0, irq_o}, 32'h1);
        check("R5 tie to lowest index", rdata, 32'h8C);
        rd("R7 winner latch cleared", 8'h01, 32'h0000_1020);

        // R9: pending write clears latches; R6 hold survives
        wr(8'h01, 32'h0);
        rd("R9 pending cleared by zero write", 8'h01, 32'h0);
        check("R6 winner held after pending cleared", {31'b0, irq_o}, 32'h1);
        wr(8'h04, 32'h1);
        idle(2);
        check("R7 nothing left to arbitrate", {31'b0, irq_o}, 32'h0);

        // R2: mask blocks arbitration but not latching
        wr(8'h00, 32'h0000_0080);
        pulse(32'h0000_0080);
        idle(4);
        check("R2 masked line gives no request", {31'b0, irq_o}, 32'h0);
        rd("R2 masked edge still latched", 8'h01, 32'h0000_0080);
        wr(8'h00, 32'h0);
        idle(3);
        check("R2 unmasked line requests", {31'b0, irq_o}, 32'h1);
        rd("R2 unmasked winner index", 8'h02, 32'h87);
        wr(8'h04, 32'h1);
        idle(2);

        // R4: level line follows input
        wr(8'h34, 32'h02);
        src = 32'h0010_0000;
        idle(3);
        check("R4 level line requests", {31'b0, irq_o}, 32'h1);
        rd("R4 level winner index", 8'h02, 32'h94);
        rd("R4 pending follows high input", 8'h01, 32'h0010_0000);
        src = '0;
        idle(2);
        rd("R4 pending follows low input", 8'h01, 32'h0);
        check("R6 output held after source dropped", {31'b0, irq_o}, 32'h1);
        wr(8'h04, 32'h1);
        idle(3);
        check("R4 level source not latched", {31'b0, irq_o}, 32'h0);

        // R8: fast routing on first level only
        wr(8'h22, 32'h01);
        addr = 8'h22;
        tick();
        check("R8 first-level keeps route bit", rdata, 32'h01);
        check("R8 second-level forces route bit", rdata2, 32'h00);
        pulse(32'h0000_0004);
        idle(3);
        check("R8 fiq_o raised", {31'b0, fiq_o}, 32'h1);
        check("R8 irq_o untouched", {31'b0, irq_o}, 32'h0);
        check("R8 second-level uses irq", {31'b0, irq2}, 32'h1);
        check("R8 second-level no fiq", {31'b0, fiq2}, 32'h0);
        rd("R8 sorted fast index", 8'h03, 32'h82);
        wr(8'h04, 32'h3);
        check("R7 fiq_o low after release", {31'b0, fiq_o}, 32'h0);
        check("R7 second-level irq released", {31'b0, irq2}, 32'h0);
        idle(3);

        // R10: bank block bit gates outputs while winner is held
        pulse(32'h0000_0020);
        idle(3);
        check("R12 irq_o for line 5", {31'b0, irq_o}, 32'h1);
        wr(8'h05, 32'h1);
        check("R10 block bit forces output low", {31'b0, irq_o}, 32'h0);
        rd("R10 winner still held", 8'h02, 32'h85);
        wr(8'h05, 32'h0);
        check("R10 output returns", {31'b0, irq_o}, 32'h1);
        wr(8'h04, 32'h3);
        idle(2);

        // Random phase, every cycle compared with the model (R5, R8, R12)
        for (int n = 0; n < 3000; n++) begin
            int op;
            src = $urandom & $urandom & $urandom;
            op  = int'($urandom_range(0, 11));
            we  = 1'b0;
            case (op)
                0: begin addr = 8'h00; wdata = $urandom & $urandom & $urandom; we = 1'b1; end
                1, 2: begin
                    addr = {3'b001, 5'($urandom)};
                    wdata = {25'b0, 7'($urandom)};
                    we = 1'b1;
                end
                3, 4: begin addr = 8'h04; wdata = {30'b0, 2'($urandom)}; we = 1'b1; end
                5: begin addr = 8'h01; wdata = $urandom | $urandom; we = 1'b1; end
                6: begin addr = 8'h05; wdata = {31'b0, ($urandom_range(0, 7) == 0)}; we = 1'b1; end
                default: begin
                    case ($urandom_range(0, 5))
                        0: addr = 8'h00;
                        1: addr = 8'h01;
                        2: addr = 8'h02;
                        3: addr = 8'h03;
                        4: addr = 8'h05;
                        default: addr = {3'b001, 5'($urandom)};
                    endcase
                end
            endcase
            tick();
        end
        we = 1'b0;
        idle(2);
        finish_run();
    end

endmodule